// File: doc/BRIEF.md
# UART Register and Interrupt Interface

This block is the software-facing register slave of a UART. It occupies a 4 KB window on a simple single-cycle request bus, with registers selected by the word address bits [11:2]. It holds the divisor, line-control, control, FIFO-level, DMA-control and infrared low-power settings as plain storage. It also keeps the raw interrupt bits and the interrupt mask, and drives one level-sensitive interrupt line. At the top of the window it presents eight read-only identification bytes.

A write to the data register hands the low byte to the transmit side on a one-cycle strobe. A read of the data register pops the attached receive FIFO. The FIFO supplies a 12-bit entry: the character in bits [7:0] and the error flags in bits [11:8]. The FIFO also supplies its empty and full levels and a strobe for each character it accepts. Serial timing, baud generation and DMA handshaking are handled elsewhere.

Top module: `uart_regs`

## Requirements
- R1: After reset these registers read as follows: FIFO-level select (word 13) 0x12, control (word 12) 0x300, flags (word 6) 0x90 while `rxEmpty` is high and `rxFull` is low. Mask (word 14) and raw status (word 15) read 0, and `irq` is low.
- R2: Storage registers keep only their low bits and read back what was written. Infrared low-power (word 8) keeps 8 bits, integer divisor (word 9) 16, fractional divisor (word 10) 6, line control (word 11) 8, control (word 12) 16, FIFO-level select (word 13) 6, mask (word 14) 11 and DMA control (word 18) 3. Every read request is answered on `busRdata` at the clock edge that samples it, and the value holds until the next read.
- R3: Every write to word 0 produces `txValid` high for exactly one cycle after the write edge, with `txByte` equal to the written bits [7:0]. The same write sets raw interrupt bit 5 (transmit).
- R4: `irq` is high exactly when (raw status AND mask) is nonzero. After a mask write, `irq` reflects the new mask from the same edge that stores it.
- R5: Writing word 17 clears each raw status bit written as 1 and leaves the others unchanged. Reading word 16 returns raw AND mask.
- R6: Raw bit 4 (receive) is set on the edge after `rxPush` is high. It is cleared by a clear-register write with bit 4 set, or when `rxEmpty` is sampled high with no `rxPush`. `rxPush` wins over both.
- R7: A read of word 0 returns `rxData` zero-extended and copies `rxData[11:8]` into the receive-status register, which reads at word 1. `rxPop` is high only during a word-0 read request while `rxEmpty` is low. Any write to word 1 clears the receive status to 0.
- R8: Flags (word 6) read bit 7 = 1 (transmit empty), bit 6 = `rxFull`, bit 5 = 0 (transmit never full), bit 4 = `rxEmpty`, and all other bits 0. Writes to word 6 change nothing.
- R9: Reads at byte addresses 0xFE0 + 4n (n = 0..7) return the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order of n.
- R10: Reads of undefined offsets (including word 17, word 7 and 0xFDC) return 0. Writes to undefined offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Request valid for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address in the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| txValid | output | 1 | One-cycle transmit byte strobe |
| txByte | output | 8 | Byte to transmit |
| rxData | input | 12 | Head entry of the receive FIFO (errors in [11:8]) |
| rxEmpty | input | 1 | Receive FIFO empty |
| rxFull | input | 1 | Receive FIFO full |
| rxPush | input | 1 | The FIFO accepted a character this cycle |
| rxPop | output | 1 | Pop the receive FIFO head |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The hardest case to reach is the receive interrupt lifecycle. The bit is set by a FIFO push and must fall only once the FIFO reports empty after the last data read. In the same flow the receive status must capture the error nibble of the popped entry. The bench drives the FIFO-side pins as a small model to walk this path. It pushes an entry carrying error bits, unmasks receive, reads the data while watching `rxPop`, and only then raises `rxEmpty`. It then confirms that the raw bit and `irq` fall one edge later and that the status survives until it is cleared.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int RX_W   = 12;
  localparam int INT_W  = 11;
  localparam int IDX_W  = 5;

  localparam logic [IDX_W-1:0] IX_DATA  = 5'd0;
  localparam logic [IDX_W-1:0] IX_RSR   = 5'd1;
  localparam logic [IDX_W-1:0] IX_FLAG  = 5'd6;
  localparam logic [IDX_W-1:0] IX_ILP   = 5'd8;
  localparam logic [IDX_W-1:0] IX_IDIV  = 5'd9;
  localparam logic [IDX_W-1:0] IX_FDIV  = 5'd10;
  localparam logic [IDX_W-1:0] IX_LINE  = 5'd11;
  localparam logic [IDX_W-1:0] IX_CTRL  = 5'd12;
  localparam logic [IDX_W-1:0] IX_LVL   = 5'd13;
  localparam logic [IDX_W-1:0] IX_MASK  = 5'd14;
  localparam logic [IDX_W-1:0] IX_RAW   = 5'd15;
  localparam logic [IDX_W-1:0] IX_MSKD  = 5'd16;
  localparam logic [IDX_W-1:0] IX_CLR   = 5'd17;
  localparam logic [IDX_W-1:0] IX_DMA   = 5'd18;
  localparam logic [IDX_W-1:0] IX_NONE  = 5'd31;

  localparam int TX_BIT = 5;
  localparam int RX_BIT = 4;

  typedef struct packed {
    logic            wrTx;
    logic            wrRsrClr;
    logic            wrIlp;
    logic            wrIdiv;
    logic            wrFdiv;
    logic            wrLine;
    logic            wrCtrl;
    logic            wrLvl;
    logic            wrMask;
    logic            wrClr;
    logic            wrDma;
    logic            rdEn;
    logic            rdPop;
    logic            rdId;
    logic [IDX_W-1:0] rdIdx;
    logic [2:0]      idIdx;
  } regStrobes_t;

  function automatic logic [7:0] idByte(input logic [2:0] n);
    case (n)
      3'd0: idByte = 8'h11;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rxEmpty,
  output regStrobes_t       strb
);
  logic [ADDR_W-3:0] wordIdx;
  logic              isWr;
  logic              isRd;
  logic              inIdWin;
  logic              known;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign isWr    = busValid && busWrite;
  assign isRd    = busValid && !busWrite;
  assign inIdWin = (busAddr[ADDR_W-1:5] == '1);

  always_comb begin
    known = 1'b0;
    case (wordIdx)
      10'd0, 10'd1, 10'd6, 10'd8, 10'd9, 10'd10, 10'd11, 10'd12,
      10'd13, 10'd14, 10'd15, 10'd16, 10'd18: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.wrTx     = isWr && (wordIdx == 10'd0);
    strb.wrRsrClr = isWr && (wordIdx == 10'd1);
    strb.wrIlp    = isWr && (wordIdx == 10'd8);
    strb.wrIdiv   = isWr && (wordIdx == 10'd9);
    strb.wrFdiv   = isWr && (wordIdx == 10'd10);
    strb.wrLine   = isWr && (wordIdx == 10'd11);
    strb.wrCtrl   = isWr && (wordIdx == 10'd12);
    strb.wrLvl    = isWr && (wordIdx == 10'd13);
    strb.wrMask   = isWr && (wordIdx == 10'd14);
    strb.wrClr    = isWr && (wordIdx == 10'd17);
    strb.wrDma    = isWr && (wordIdx == 10'd18);
    strb.rdEn     = isRd;
    strb.rdPop    = isRd && (wordIdx == 10'd0) && !rxEmpty;
    strb.rdId     = isRd && inIdWin;
    strb.idIdx    = busAddr[4:2];
    strb.rdIdx    = known ? wordIdx[IDX_W-1:0] : IX_NONE;
  end
endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [RX_W-1:0]   rxData,
  input  logic              rxEmpty,
  input  logic              rxFull,
  input  logic              rxPush,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic [INT_W-1:0]  rawBits,
  output logic [INT_W-1:0]  maskBits,
  output logic              irq
);
  logic [7:0]       ilpReg;
  logic [15:0]      idivReg;
  logic [5:0]       fdivReg;
  logic [7:0]       lineReg;
  logic [15:0]      ctrlReg;
  logic [5:0]       lvlReg;
  logic [2:0]       dmaReg;
  logic [3:0]       rsrReg;
  logic [7:0]       flagVal;
  logic [DATA_W-1:0] rdNext;

  assign flagVal = {1'b1, rxFull, 1'b0, rxEmpty, 4'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ilpReg   <= '0;
      idivReg  <= '0;
      fdivReg  <= '0;
      lineReg  <= '0;
      ctrlReg  <= 16'h0300;
      lvlReg   <= 6'h12;
      dmaReg   <= '0;
      maskBits <= '0;
    end else begin
      if (strb.wrIlp)  ilpReg   <= busWdata[7:0];
      if (strb.wrIdiv) idivReg  <= busWdata[15:0];
      if (strb.wrFdiv) fdivReg  <= busWdata[5:0];
      if (strb.wrLine) lineReg  <= busWdata[7:0];
      if (strb.wrCtrl) ctrlReg  <= busWdata[15:0];
      if (strb.wrLvl)  lvlReg   <= busWdata[5:0];
      if (strb.wrDma)  dmaReg   <= busWdata[2:0];
      if (strb.wrMask) maskBits <= busWdata[INT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawBits <= '0;
    end else begin
      for (int b = 0; b < INT_W; b++) begin
        if (b == TX_BIT && strb.wrTx)
          rawBits[b] <= 1'b1;
        else if (b == RX_BIT && rxPush)
          rawBits[b] <= 1'b1;
        else if (strb.wrClr && busWdata[b])
          rawBits[b] <= 1'b0;
        else if (b == RX_BIT && rxEmpty)
          rawBits[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
      rsrReg  <= '0;
    end else begin
      txValid <= strb.wrTx;
      if (strb.wrTx) txByte <= busWdata[7:0];
      if (strb.wrRsrClr)
        rsrReg <= '0;
      else if (strb.rdEn && strb.rdIdx == IX_DATA)
        rsrReg <= rxData[RX_W-1:8];
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdId) begin
      rdNext[7:0] = idByte(strb.idIdx);
    end else begin
      case (strb.rdIdx)
        IX_DATA: rdNext[RX_W-1:0]  = rxData;
        IX_RSR:  rdNext[3:0]       = rsrReg;
        IX_FLAG: rdNext[7:0]       = flagVal;
        IX_ILP:  rdNext[7:0]       = ilpReg;
        IX_IDIV: rdNext[15:0]      = idivReg;
        IX_FDIV: rdNext[5:0]       = fdivReg;
        IX_LINE: rdNext[7:0]       = lineReg;
        IX_CTRL: rdNext[15:0]      = ctrlReg;
        IX_LVL:  rdNext[5:0]       = lvlReg;
        IX_MASK: rdNext[INT_W-1:0] = maskBits;
        IX_RAW:  rdNext[INT_W-1:0] = rawBits;
        IX_MSKD: rdNext[INT_W-1:0] = rawBits & maskBits;
        IX_DMA:  rdNext[2:0]       = dmaReg;
        default: rdNext            = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      busRdata <= '0;
    else if (strb.rdEn)
      busRdata <= rdNext;
  end

  assign irq = |(rawBits & maskBits);
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        txValid,
  output logic [7:0]  txByte,
  input  logic [11:0] rxData,
  input  logic        rxEmpty,
  input  logic        rxFull,
  input  logic        rxPush,
  output logic        rxPop,
  output logic        irq
);
  regStrobes_t      strb;
  logic [INT_W-1:0] rawBits;
  logic [INT_W-1:0] maskBits;

  uart_regs_ctrl u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .rxEmpty  (rxEmpty),
    .strb     (strb)
  );

  uart_regs_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .rxData   (rxData),
    .rxEmpty  (rxEmpty),
    .rxFull   (rxFull),
    .rxPush   (rxPush),
    .busRdata (busRdata),
    .txValid  (txValid),
    .txByte   (txByte),
    .rawBits  (rawBits),
    .maskBits (maskBits),
    .irq      (irq)
  );

  assign rxPop = strb.rdPop;
endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [11:0] busAddr,
  input logic [31:0] busWdata,
  input logic        txValid,
  input logic [7:0]  txByte,
  input logic        rxPush,
  input logic        rxPop,
  input logic [10:0] rawBits,
  input logic [10:0] maskBits,
  input logic        irq
);
  logic dataWr;
  logic clrWr;
  assign dataWr = busValid && busWrite && (busAddr[11:2] == 10'd0);
  assign clrWr  = busValid && busWrite && (busAddr[11:2] == 10'd17);

  a_r3_tx_strobe: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> (txValid && txByte == $past(busWdata[7:0])));

  a_r3_tx_only_after_write: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(dataWr));

  a_r3_raw_tx_set: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> rawBits[5]);

  a_r5_clear_tx: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && busWdata[5]) |=> !rawBits[5]);

  a_r6_rx_set: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> rawBits[4]);

  a_r7_pop_on_read: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (busValid && !busWrite && busAddr[11:2] == 10'd0));

  a_r4_mask_write_irq: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr[11:2] == 10'd14 && busWdata[10:0] == 11'd0)
      |=> !irq);
endmodule

bind uart_regs uart_regs_chk chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .txValid  (txValid),
  .txByte   (txByte),
  .rxPush   (rxPush),
  .rxPop    (rxPop),
  .rawBits  (rawBits),
  .maskBits (maskBits),
  .irq      (irq)
);

// File: tb/uart_regs_test.sv
`timescale 1ns/1ps
module uart_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txValid;
  logic [7:0]  txByte;
  logic [11:0] rxData = '0;
  logic        rxEmpty = 1'b1;
  logic        rxFull = 1'b0;
  logic        rxPush = 1'b0;
  logic        rxPop;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_regs uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txValid(txValid), .txByte(txByte), .rxData(rxData), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .rxPush(rxPush), .rxPop(rxPop), .irq(irq)
  );

  // {write, addr, wdata, expected read}
  localparam int NV = 30;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0},  {1'b0, 12'h020, 32'h0, 32'h0000_00FF},
    {1'b1, 12'h024, 32'h1234_ABCD, 32'h0},  {1'b0, 12'h024, 32'h0, 32'h0000_ABCD},
    {1'b1, 12'h028, 32'h0000_00FF, 32'h0},  {1'b0, 12'h028, 32'h0, 32'h0000_003F},
    {1'b1, 12'h02C, 32'h0000_01F0, 32'h0},  {1'b0, 12'h02C, 32'h0, 32'h0000_00F0},
    {1'b1, 12'h030, 32'hFFFF_0301, 32'h0},  {1'b0, 12'h030, 32'h0, 32'h0000_0301},
    {1'b1, 12'h034, 32'h0000_00FF, 32'h0},  {1'b0, 12'h034, 32'h0, 32'h0000_003F},
    {1'b1, 12'h048, 32'h0000_000F, 32'h0},  {1'b0, 12'h048, 32'h0, 32'h0000_0007},
    {1'b1, 12'h038, 32'h0000_FFFF, 32'h0},  {1'b0, 12'h038, 32'h0, 32'h0000_07FF},
    {1'b1, 12'h038, 32'h0000_0000, 32'h0},  {1'b0, 12'h044, 32'h0, 32'h0000_0000},
    {1'b1, 12'h01C, 32'h0000_00FF, 32'h0},  {1'b0, 12'h01C, 32'h0, 32'h0000_0000},
    {1'b0, 12'hFDC, 32'h0, 32'h0000_0000},  {1'b0, 12'hFE0, 32'h0, 32'h0000_0011},
    {1'b0, 12'hFE4, 32'h0, 32'h0000_0010},  {1'b0, 12'hFE8, 32'h0, 32'h0000_0014},
    {1'b0, 12'hFEC, 32'h0, 32'h0000_0000},  {1'b0, 12'hFF0, 32'h0, 32'h0000_000D},
    {1'b0, 12'hFF4, 32'h0, 32'h0000_00F0},  {1'b0, 12'hFF8, 32'h0, 32'h0000_0005},
    {1'b0, 12'hFFC, 32'h0, 32'h0000_00B1},  {1'b1, 12'h018, 32'h0000_0000, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRd(a, d);
    check(req, d, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rdChk("R1 level", 12'h034, 32'h12);
    rdChk("R1 control", 12'h030, 32'h300);
    rdChk("R1 flags", 12'h018, 32'h90);
    rdChk("R1 mask", 12'h038, 32'h0);
    rdChk("R1 raw", 12'h03C, 32'h0);

    // R2 R9 R10 R8 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) busWr(VEC[i][75:64], VEC[i][63:32]);
      else rdChk("R2/R9/R10 vector", VEC[i][75:64], VEC[i][31:0]);
    end
    rdChk("R8 flag write ignored", 12'h018, 32'h90);
    rdChk("R10 undefined write no effect on level", 12'h034, 32'h3F);

    // R3 transmit
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 12'h000; busWdata = 32'h1A5;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    check("R3 txValid", {31'b0, txValid}, 32'h1);
    check("R3 txByte", {24'b0, txByte}, 32'hA5);
    @(negedge clk);
    check("R3 txValid one cycle", {31'b0, txValid}, 32'h0);
    rdChk("R3 raw tx bit", 12'h03C, 32'h20);
    check("R4 masked off irq", {31'b0, irq}, 32'h0);

    // R4 mask write
    busWr(12'h038, 32'h20);
    check("R4 irq after mask", {31'b0, irq}, 32'h1);
    rdChk("R5 masked status", 12'h040, 32'h20);

    // R5 clear
    busWr(12'h044, 32'h10);
    rdChk("R5 clear other bit keeps tx", 12'h03C, 32'h20);
    busWr(12'h044, 32'h20);
    check("R5 irq after clear", {31'b0, irq}, 32'h0);
    rdChk("R5 raw after clear", 12'h03C, 32'h0);

    // R6 receive interrupt
    @(negedge clk);
    rxEmpty = 1'b0; rxData = 12'h5C3; rxPush = 1'b1;
    @(negedge clk);
    rxPush = 1'b0;
    rdChk("R6 raw rx set", 12'h03C, 32'h10);
    busWr(12'h038, 32'h10);
    check("R6 irq rx", {31'b0, irq}, 32'h1);

    // R7 data read pops and captures status
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 12'h000;
    #1 check("R7 rxPop during read", {31'b0, rxPop}, 32'h1);
    @(negedge clk);
    busValid = 1'b0;
    check("R7 read data", busRdata, 32'h5C3);
    rxEmpty = 1'b1;
    @(negedge clk);
    check("R6 irq falls after empty", {31'b0, irq}, 32'h0);
    rdChk("R6 raw rx cleared", 12'h03C, 32'h0);
    rdChk("R7 status captured", 12'h004, 32'h5);
    busWr(12'h004, 32'hFFFF);
    rdChk("R7 status cleared", 12'h004, 32'h0);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 12'h000;
    #1 check("R7 no pop when empty", {31'b0, rxPop}, 32'h0);
    @(negedge clk);
    busValid = 1'b0;

    // R8 full flag
    rxEmpty = 1'b0; rxFull = 1'b1;
    rdChk("R8 flags full", 12'h018, 32'hC0);
    rxEmpty = 1'b1; rxFull = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule